// File: doc/BRIEF.md
# SMBus Block-Transfer Slave

This block is the slave end of a two-wire serial bus. It handles two kinds of transfer to a small group of local byte ports: block writes into a write-data port, and block reads out of a receive buffer. Both bus lines pass through synchronisers and a deglitch filter. Edge logic then finds START, repeated START, STOP and the clock edges. A state machine matches a 7-bit device address, captures a register-address byte, and then either accepts a stream of bytes or turns the bus around and sends one.

On a write, the byte after the register address is a length field. The block acknowledges it but does not use its value. Every later data byte is acknowledged and pushed out as a one-cycle `wr_valid` strobe, with no limit on how many arrive. On a read, the master writes the register address, issues a repeated START, and sends the device address again with the direction bit set. The slave then sends a count byte: 32 when 32 or more bytes remain, otherwise the number that remain. After the count it sends buffer bytes for as long as the master acknowledges them. The buffer is first-word-fall-through: `rd_data` shows its head byte and `rd_pop` removes that byte.

States: `ST_IDLE` (bus free), `ST_ADDR` (shift in address and direction), `ST_REG` (shift in register address), `ST_WCNT` (shift in the write length), `ST_WDATA` (shift in a data byte), `ST_ACK` (hold data low for one clock), `ST_TXCNT` / `ST_TXDATA` (shift out the count or a data byte), `ST_MACK` (sample the master's acknowledge) and `ST_SKIP` (hands off until the next START or STOP). Transitions: STOP goes from any state to `ST_IDLE`, and START goes from any state to `ST_ADDR`. The eighth falling clock of a byte goes from `ST_ADDR` to `ST_ACK` on a match, or to `ST_SKIP` on a mismatch. The eighth falling clock goes from `ST_REG`, `ST_WCNT` or `ST_WDATA` to `ST_ACK`. The ninth falling clock goes from `ST_ACK` to the stored return state: `ST_REG`, `ST_WCNT`, `ST_WDATA` or `ST_TXCNT`. The eighth falling clock goes from `ST_TXCNT` or `ST_TXDATA` to `ST_MACK`. The falling clock after the acknowledge bit goes from `ST_MACK` to `ST_TXDATA` on an ACK, or to `ST_SKIP` on a NACK.

Top module: `smb_block_slave`

## Requirements
- R1: An address byte whose upper seven bits equal `SLAVE_ADDR` is acknowledged by pulling the data line low during the ninth clock. Bit 0 of that byte selects the direction: 0 for write, 1 for read.
- R2: An address byte that does not match is not acknowledged. The slave then does not pull the data line low until the next START, and it pushes nothing.
- R3: The byte after a matching write address is acknowledged and appears on `reg_addr`, whatever its value.
- R4: In a write, the byte after the register address is acknowledged and never pushed on `wr_valid`. Its value has no effect on how many bytes are accepted.
- R5: Every later write byte is acknowledged and pushed once, MSB-first assembled, as a single-cycle `wr_valid` pulse. More than 32 bytes are accepted.
- R6: After a repeated START and a matching read address, the first byte sent, MSB first, is 32 when `rd_remain` is 32 or more, and `rd_remain` otherwise.
- R7: Each ACK from the master makes the slave pop one byte and send it, MSB first, past 32 bytes if the master keeps acknowledging.
- R8: After a NACK the slave releases the data line and pops nothing more.
- R9: A STOP returns the slave to idle with the line released. A repeated START during a write restarts address matching, and the new register address replaces the old one.
- R10: The slave changes its data-line drive only while the filtered clock is low.
- R11: While reset is held, `sda_oe`, `wr_valid` and `rd_pop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| reg_addr | output | 8 | Last captured register-address byte |
| wr_valid | output | 1 | One-cycle push strobe for a written byte |
| wr_data | output | 8 | Byte pushed with `wr_valid` |
| rd_data | input | 8 | Head byte of the receive buffer |
| rd_remain | input | CNT_W | Bytes left in the receive buffer |
| rd_pop | output | 1 | One-cycle pop strobe for the receive buffer |

## Verification
A corrupted state or bit counter appears on the bus within one byte time. The expected acknowledge is then missing during the ninth clock, or the master sees a shifted or wrong bit in the count or a data byte. A wrong return state after an acknowledge appears at the next byte: a length byte comes out as a push, or a read starts without its count byte. Drive or pop errors around a NACK appear before or at the following STOP. They show as a line held low, or as one pop too many in the buffer model.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WCNT,
        ST_WDATA,
        ST_ACK,
        ST_TXCNT,
        ST_TXDATA,
        ST_MACK,
        ST_SKIP
    } smb_state_e;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW  = $clog2(FILT_LEN + 1);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   flt_q;

    // Sync chain, then a level that must differ FILT_LEN cycles in a row
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            run_q  <= '0;
            flt_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (sync_q[TOP] == flt_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                flt_q <= sync_q[TOP];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign flt_o = flt_q;

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    // Data edges while the clock stays high are bus conditions
    always_comb begin
        ev_start = scl_p && scl_f && sda_p && !sda_f;
        ev_stop  = scl_p && scl_f && !sda_p && sda_f;
        ev_rise  = !scl_p && scl_f;
        ev_fall  = scl_p && !scl_f;
    end

endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h5A,
    parameter int         CHUNK      = 32,
    parameter int         CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_f,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_rise,
    input  logic             ev_fall,
    input  logic [7:0]       rd_data,
    input  logic [CNT_W-1:0] rd_remain,
    output logic             sda_oe,
    output logic [7:0]       reg_addr,
    output logic             wr_valid,
    output logic [7:0]       wr_data,
    output logic             rd_pop
);
    localparam logic [CNT_W-1:0] CHUNK_W = CNT_W'(CHUNK);
    localparam logic [7:0]       CHUNK_B = 8'(CHUNK);

    smb_state_e state_q, nxt;
    smb_state_e ret_q, ret_d;
    logic [7:0] sh_q;
    logic [3:0] bit_q;
    logic       mack_seen_q;
    logic       mack_ok_q;
    logic [7:0] cnt_byte;

    assign cnt_byte = (rd_remain >= CHUNK_W) ? CHUNK_B : rd_remain[7:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state_q;
        if (ev_stop) begin
            nxt = ST_IDLE;
        end else if (ev_start) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: begin
                    if (ev_fall && bit_q == 4'd8)
                        nxt = (sh_q[7:1] == SLAVE_ADDR) ? ST_ACK : ST_SKIP;
                end
                ST_REG, ST_WCNT, ST_WDATA: begin
                    if (ev_fall && bit_q == 4'd8) nxt = ST_ACK;
                end
                ST_ACK: begin
                    if (ev_fall) nxt = ret_q;
                end
                ST_TXCNT, ST_TXDATA: begin
                    if (ev_fall && bit_q == 4'd7) nxt = ST_MACK;
                end
                ST_MACK: begin
                    if (ev_fall && mack_seen_q)
                        nxt = mack_ok_q ? ST_TXDATA : ST_SKIP;
                end
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Where to resume after the acknowledge bit
    always_comb begin
        case (state_q)
            ST_ADDR: ret_d = sh_q[0] ? ST_TXCNT : ST_REG;
            ST_REG:  ret_d = ST_WCNT;
            default: ret_d = ST_WDATA;
        endcase
    end

    // Datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q       <= ST_REG;
            sh_q        <= '0;
            bit_q       <= '0;
            mack_seen_q <= 1'b0;
            mack_ok_q   <= 1'b0;
            reg_addr    <= '0;
            wr_valid    <= 1'b0;
            wr_data     <= '0;
            rd_pop      <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_pop   <= 1'b0;
            if (ev_stop || ev_start) begin
                bit_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_REG, ST_WCNT, ST_WDATA: begin
                        if (ev_rise) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            bit_q <= bit_q + 1'b1;
                        end else if (ev_fall && bit_q == 4'd8) begin
                            ret_q <= ret_d;
                            bit_q <= '0;
                            if (state_q == ST_REG) reg_addr <= sh_q;
                            if (state_q == ST_WDATA) begin
                                wr_valid <= 1'b1;
                                wr_data  <= sh_q;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev_fall) begin
                            bit_q <= '0;
                            if (ret_q == ST_TXCNT) sh_q <= cnt_byte;
                        end
                    end
                    ST_TXCNT, ST_TXDATA: begin
                        if (ev_fall) begin
                            if (bit_q == 4'd7) begin
                                bit_q       <= '0;
                                mack_seen_q <= 1'b0;
                            end else begin
                                sh_q  <= {sh_q[6:0], 1'b0};
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev_rise) begin
                            mack_seen_q <= 1'b1;
                            mack_ok_q   <= !sda_f;
                        end else if (ev_fall && mack_seen_q && mack_ok_q) begin
                            sh_q   <= rd_data;
                            rd_pop <= 1'b1;
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        bit_q <= '0;
                    end
                    default: bit_q <= '0;
                endcase
            end
        end
    end

    // Line drive: ack bit, or a 0 data bit while transmitting
    always_comb begin
        sda_oe = (state_q == ST_ACK) ||
                 (((state_q == ST_TXCNT) || (state_q == ST_TXDATA)) && !sh_q[7]);
    end

endmodule

// File: rtl/smb_block_slave.sv
module smb_block_slave #(
    parameter logic [6:0] SLAVE_ADDR  = 7'h5A,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter int         CHUNK       = 32,
    parameter int         CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [7:0]       reg_addr,
    output logic             wr_valid,
    output logic [7:0]       wr_data,
    input  logic [7:0]       rd_data,
    input  logic [CNT_W-1:0] rd_remain,
    output logic             rd_pop
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_v;
    logic [LINES-1:0] flt_v;
    logic             scl_flt;
    logic             sda_flt;
    logic             ev_start, ev_stop, ev_rise, ev_fall;

    assign raw_v = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        smb_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(raw_v[g]),
            .flt_o(flt_v[g])
        );
    end

    assign scl_flt = flt_v[1];
    assign sda_flt = flt_v[0];

    smb_cond_detect u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_flt),
        .sda_f   (sda_flt),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    smb_slave_fsm #(
        .SLAVE_ADDR(SLAVE_ADDR),
        .CHUNK     (CHUNK),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_f    (sda_flt),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .rd_data  (rd_data),
        .rd_remain(rd_remain),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_pop   (rd_pop)
    );

endmodule

// File: rtl/smb_slave_chk.sv
module smb_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic sda_oe,
    input logic wr_valid,
    input logic rd_pop
);
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    a_r5_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r5_push_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !scl_f);

    a_r7_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |=> !rd_pop);

    a_r7_pop_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> !scl_f);

    a_r4_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_pop));

endmodule

bind smb_block_slave smb_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_flt),
    .sda_oe  (sda_oe),
    .wr_valid(wr_valid),
    .rd_pop  (rd_pop)
);

// File: tb/sim_smb_block_slave.sv
module sim_smb_block_slave;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 12;
    localparam int         WATCHDOG   = 190000;
    localparam logic [6:0] SADDR      = 7'h5A;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    wire         sda_bus;
    logic        sda_oe, wr_valid, rd_pop;
    logic [7:0]  reg_addr, wr_data;
    logic [7:0]  rd_data = 8'h00;
    logic [15:0] rd_remain = 16'd0;

    assign sda_bus = ~(m_low | sda_oe);

    smb_block_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_data(rd_data), .rd_remain(rd_remain),
        .rd_pop(rd_pop)
    );

    logic [7:0] exp_wr[$];
    logic [7:0] rd_q[$];
    logic [7:0] rd_exp[$];
    logic [7:0] exp_b;
    int  vecs = 0, errs = 0, pops = 0, drive_seen = 0, oe_scl_high = 0;
    bit  watch_drive = 0, done = 0, oe_prev = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    // Monitor: write scoreboard, buffer model, drive observers
    always @(negedge clk) begin
        if (wr_valid) begin
            if (exp_wr.size() == 0) begin
                vecs++; errs++;
                $display("FAIL R4/R5 unexpected push actual=%0h expected=none", wr_data);
            end else begin
                exp_b = exp_wr.pop_front();
                chk("R5 pushed byte", wr_data, exp_b);
            end
        end
        if (rd_pop) begin
            pops++;
            if (rd_q.size() > 0) void'(rd_q.pop_front());
        end
        rd_data   = (rd_q.size() > 0) ? rd_q[0] : 8'h00;
        rd_remain = 16'(rd_q.size());
        if (watch_drive && sda_oe) drive_seen++;
        if (rst_n && (sda_oe !== oe_prev) && m_scl) oe_scl_high++;
        oe_prev = sda_oe;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; m_scl = 1'b1; wq();
        m_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_low = 1'b0; wq();
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; wq();
        m_scl = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        b = sda_bus;
        m_scl = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic do_read(input int n, input int exp_cnt);
        logic       ack;
        logic [7:0] v;
        rd_exp = rd_q;
        pops = 0;
        bus_start();
        wbyte({SADDR, 1'b0}, ack); chk("R1 read-setup address ack", ack, 1);
        wbyte(8'h40, ack);         chk("R3 read register ack", ack, 1);
        bus_rstart();
        wbyte({SADDR, 1'b1}, ack); chk("R1 read address ack", ack, 1);
        rbyte(v, 1'b1);            chk("R6 count byte", v, exp_cnt);
        for (int i = 0; i < n; i++) begin
            rbyte(v, i != n - 1);
            chk("R7 read data byte", v, rd_exp[i]);
        end
        bus_stop();
        repeat (20) @(negedge clk);
        chk("R8 pops after NACK", pops, n);
        chk("R8 line released", sda_oe, 0);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        chk("R11 sda_oe in reset", sda_oe, 0);
        chk("R11 wr_valid in reset", wr_valid, 0);
        chk("R11 rd_pop in reset", rd_pop, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // Block write of 34 bytes with a length field of 5
        bus_start();
        wbyte({SADDR, 1'b0}, ack); chk("R1 write address ack", ack, 1);
        wbyte(8'h21, ack);         chk("R3 register ack", ack, 1);
        chk("R3 reg_addr captured", reg_addr, 8'h21);
        wbyte(8'h05, ack);         chk("R4 length ack", ack, 1);
        for (int i = 0; i < 34; i++) begin
            d = 8'(i * 7 + 3);
            exp_wr.push_back(d);
            wbyte(d, ack);
            chk("R5 data ack", ack, 1);
        end
        bus_stop();
        repeat (20) @(negedge clk);
        chk("R4 every byte pushed, length not pushed", exp_wr.size(), 0);
        chk("R9 idle after STOP", sda_oe, 0);

        // Address mismatch
        watch_drive = 1;
        bus_start();
        wbyte({7'h2B, 1'b0}, ack); chk("R2 mismatch no ack", ack, 0);
        wbyte(8'h40, ack);         chk("R2 following byte no ack", ack, 0);
        bus_stop();
        watch_drive = 0;
        chk("R2 never drove line", drive_seen, 0);

        // Reads: 40 buffered, read 36 past the count, then 4 left
        for (int i = 0; i < 40; i++) rd_q.push_back(8'(8'hC0 ^ (i * 5)));
        repeat (2) @(negedge clk);
        do_read(36, 32);
        do_read(4, 4);

        // Repeated START in the middle of a write
        bus_start();
        wbyte({SADDR, 1'b0}, ack); chk("R1 address ack", ack, 1);
        wbyte(8'h21, ack);         chk("R3 register ack", ack, 1);
        wbyte(8'hFF, ack);         chk("R4 length ack", ack, 1);
        exp_wr.push_back(8'hA5);
        wbyte(8'hA5, ack);         chk("R5 data ack", ack, 1);
        bus_rstart();
        wbyte({SADDR, 1'b0}, ack); chk("R9 address ack after restart", ack, 1);
        wbyte(8'h33, ack);         chk("R9 register ack after restart", ack, 1);
        chk("R9 new reg_addr", reg_addr, 8'h33);
        wbyte(8'h01, ack);         chk("R4 length ack after restart", ack, 1);
        exp_wr.push_back(8'h5C);
        wbyte(8'h5C, ack);         chk("R5 data ack after restart", ack, 1);
        bus_stop();
        repeat (20) @(negedge clk);
        chk("R9 pushes after restart", exp_wr.size(), 0);
        chk("R10 drive changed while clock high", oe_scl_high, 0);

        done = 1;
        summary();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            vecs++; errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

endmodule